// File: doc/BRIEF.md
# ADC Result Register Bank

This block stores the results produced by an analog-to-digital converter and lets a simple bus read them. It has one result register per analog input channel and three more: one for the self-diagnosis conversion, one for the temperature sensor conversion and one for the internal reference conversion. The converter side delivers a 12-bit sample with an index and a valid strobe. The bus side asks for a register by index and gets the 16-bit value on the next cycle.

Two optional behaviours sit on the write and read paths. In addition mode, the converter samples the same input two, three or four times in a row. The block adds the samples in a private accumulator and writes the register once, with the sum, after the last sample. In auto-clear mode, a bus read sets the register to zero right after returning it. Software that later finds zero can then tell that no new conversion landed. A format input sets how each value is placed in the 16-bit register when it is written: right-justified or left-justified.

Top module: `adc_result_bank`

## Requirements
- R1: After reset, every result register and `rd_data` are 0000h.
- R2: Index map with `NUM_CH` = 8:
  - Indices 0 to 7 are the analog channels.
  - Index 8 is self-diagnosis, 9 is temperature and 10 is internal reference.
  - A read with `rd_en` returns the selected register on `rd_data` one cycle later, and `rd_data` holds until the next read.
  - A read of an index above 10 returns 0000h.
- R3: The format is taken when the register is written. For a single sample, `cfg_left_align` = 0 puts it in bits 11:0 with bits 15:12 zero, and `cfg_left_align` = 1 puts it in bits 15:4 with bits 3:0 zero. Changing the format later does not change stored values.
- R4: With `cfg_auto_clear` = 0, a read leaves the register unchanged, so repeated reads return the same value.
- R5: With `cfg_auto_clear` = 1, a read returns the stored value and leaves the register at 0000h.
- R6: With `cfg_add_cnt` = 1, 2 or 3, the register receives the sum of 2, 3 or 4 consecutive samples. The 14-bit sum is placed in bits 13:0 (right) or bits 15:2 (left).
- R7: In addition mode, the register is not written before the final sample of a group. The accumulator restarts at the first sample of each group.
- R8: Addition applies only to analog channels and the internal reference. Diagnosis and temperature samples are stored as single samples even in addition mode, and they neither advance nor reset a group in progress.
- R9: When a read and a write target the same register in one cycle, `rd_data` returns the prior value and the register takes the new value, uncleared even with auto-clear on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_left_align | input | 1 | 1 = left-justify values written from now on |
| cfg_auto_clear | input | 1 | 1 = clear a register after it is read |
| cfg_add_cnt | input | 2 | 0 = no addition; 1/2/3 = sum 2/3/4 samples |
| smp_valid | input | 1 | Sample strobe from the converter |
| smp_idx | input | 4 | Register index of the sample |
| smp_data | input | 12 | Converted sample |
| rd_en | input | 1 | Bus read request |
| rd_idx | input | 4 | Register index to read |
| rd_data | output | 16 | Read data, valid the cycle after `rd_en` |

## Verification
Single samples use values with distinct nibbles written under both formats. This shows a wrong shift, a missing zero pad, or a format applied at read time instead of write time. Addition groups of each length use all-ones samples, which exposes sum truncation, and unequal samples, which exposes dropped or repeated terms. Back-to-back groups on one channel show whether the accumulator restarts. A temperature sample inserted in the middle of a channel group separates the register kinds that accumulate from those that do not. Read pairs with auto-clear off and on, plus a read and write to the same register in one cycle, show the clear rule and the write-over-clear priority.

// File: rtl/adc_rb_pkg.sv
package adc_rb_pkg;
    localparam int SMP_W  = 12;
    localparam int SUM_W  = 14;
    localparam int DATA_W = 16;

    function automatic logic [DATA_W-1:0] fmt_single(input logic [SMP_W-1:0] s, input logic left);
        return left ? {s, {(DATA_W-SMP_W){1'b0}}} : {{(DATA_W-SMP_W){1'b0}}, s};
    endfunction

    function automatic logic [DATA_W-1:0] fmt_sum(input logic [SUM_W-1:0] s, input logic left);
        return left ? {s, {(DATA_W-SUM_W){1'b0}}} : {{(DATA_W-SUM_W){1'b0}}, s};
    endfunction
endpackage

// File: rtl/adc_rb_accum.sv
module adc_rb_accum
    import adc_rb_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_left_align,
    input  logic [1:0]        cfg_add_cnt,
    input  logic              smp_valid,
    input  logic [IDX_W-1:0]  smp_idx,
    input  logic [SMP_W-1:0]  smp_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_val
);
    localparam logic [IDX_W-1:0] LAST_CH = IDX_W'(NUM_CH - 1);
    localparam logic [IDX_W-1:0] REF_IDX = IDX_W'(NUM_CH + 2);

    typedef struct packed {
        logic [SUM_W-1:0] acc;
        logic [1:0]       cnt;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic             in_range;
    logic             addable;
    logic [SUM_W-1:0] sum;

    always_comb begin
        st_d     = st_q;
        wr_en    = 1'b0;
        wr_idx   = smp_idx;
        wr_val   = '0;
        in_range = (smp_idx <= REF_IDX);
        addable  = (smp_idx <= LAST_CH) || (smp_idx == REF_IDX);
        sum      = (st_q.cnt == 2'd0) ? {2'b00, smp_data}
                                      : st_q.acc + {2'b00, smp_data};
        if (smp_valid && in_range) begin
            if ((cfg_add_cnt != 2'd0) && addable) begin
                if (st_q.cnt >= cfg_add_cnt) begin
                    wr_en    = 1'b1;
                    wr_val   = fmt_sum(sum, cfg_left_align);
                    st_d.cnt = 2'd0;
                    st_d.acc = '0;
                end else begin
                    st_d.acc = sum;
                    st_d.cnt = st_q.cnt + 2'd1;
                end
            end else begin
                wr_en  = 1'b1;
                wr_val = fmt_single(smp_data, cfg_left_align);
            end
        end
        if (cfg_add_cnt == 2'd0) begin
            st_d.cnt = 2'd0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: the opening sample of a group never writes a register
    assert_no_early_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && cfg_add_cnt != 2'd0 && addable && st_q.cnt == 2'd0) |-> !wr_en);

    // R8: diagnosis and temperature samples leave the group count alone
    assert_side_idx_keeps_cnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && in_range && !addable && cfg_add_cnt != 2'd0) |=> $stable(st_q.cnt));
endmodule

// File: rtl/adc_rb_regfile.sv
module adc_rb_regfile
    import adc_rb_pkg::*;
#(
    parameter int NUM_REG = 11,
    parameter int IDX_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_auto_clear,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_val,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REG - 1);

    typedef struct packed {
        logic [NUM_REG-1:0][DATA_W-1:0] regs;
        logic [DATA_W-1:0]              rd;
    } rf_state_t;

    rf_state_t st_d, st_q;
    logic rd_ok, wr_ok;

    always_comb begin
        st_d  = st_q;
        rd_ok = (rd_idx <= LAST_IDX);
        wr_ok = (wr_idx <= LAST_IDX);
        if (rd_en) begin
            st_d.rd = rd_ok ? st_q.regs[rd_idx] : '0;
            if (cfg_auto_clear && rd_ok) begin
                st_d.regs[rd_idx] = '0;
            end
        end
        if (wr_en && wr_ok) begin
            st_d.regs[wr_idx] = wr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rd;

    // R5: a read with auto-clear and no competing write leaves zero behind
    assert_clear_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cfg_auto_clear && rd_ok && !(wr_en && wr_idx == rd_idx))
        |=> st_q.regs[$past(rd_idx)] == '0);

    // R9: a write in the same cycle as a read of that register is kept
    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ok && rd_en && rd_idx == wr_idx)
        |=> st_q.regs[$past(wr_idx)] == $past(wr_val));

    // R4: an untouched register holds its value
    for (genvar i = 0; i < NUM_REG; i++) begin : g_hold
        assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!(wr_en && wr_idx == IDX_W'(i)) && !(rd_en && cfg_auto_clear && rd_idx == IDX_W'(i)))
            |=> $stable(st_q.regs[i]));
    end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_rb_pkg::*;
#(
    parameter int NUM_CH  = 8,
    localparam int NUM_REG = NUM_CH + 3,
    localparam int IDX_W   = $clog2(NUM_REG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_left_align,
    input  logic              cfg_auto_clear,
    input  logic [1:0]        cfg_add_cnt,
    input  logic              smp_valid,
    input  logic [IDX_W-1:0]  smp_idx,
    input  logic [SMP_W-1:0]  smp_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_val;

    adc_rb_accum #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_accum (
        .clk(clk), .rst_n(rst_n),
        .cfg_left_align(cfg_left_align), .cfg_add_cnt(cfg_add_cnt),
        .smp_valid(smp_valid), .smp_idx(smp_idx), .smp_data(smp_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val)
    );

    adc_rb_regfile #(.NUM_REG(NUM_REG), .IDX_W(IDX_W)) u_regfile (
        .clk(clk), .rst_n(rst_n), .cfg_auto_clear(cfg_auto_clear),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    // R3: left-justified writes keep the low pad bits zero
    assert_left_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && wr_en && cfg_left_align) |-> wr_val[1:0] == 2'b00);

    // R3: right-justified single samples keep the top nibble zero
    assert_right_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && wr_en && !cfg_left_align && cfg_add_cnt == 2'd0) |-> wr_val[15:12] == 4'h0);
endmodule

// File: tb/tb_adc_result_bank.sv
module tb_adc_result_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_left_align = 1'b0;
    logic        cfg_auto_clear = 1'b0;
    logic [1:0]  cfg_add_cnt = 2'd0;
    logic        smp_valid = 1'b0;
    logic [3:0]  smp_idx = '0;
    logic [11:0] smp_data = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_idx = '0;
    logic [15:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    adc_result_bank dut (
        .clk(clk), .rst_n(rst_n), .cfg_left_align(cfg_left_align),
        .cfg_auto_clear(cfg_auto_clear), .cfg_add_cnt(cfg_add_cnt),
        .smp_valid(smp_valid), .smp_idx(smp_idx), .smp_data(smp_data),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic put(input logic [3:0] idx, input logic [11:0] d);
        @(negedge clk);
        smp_valid = 1'b1; smp_idx = idx; smp_data = d;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic get(input logic [3:0] idx, output logic [15:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_idx = idx;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 rd_data after reset", rd_data, 16'h0000);
        for (int i = 0; i < 11; i++) begin
            get(4'(i), v);
            check("R1 register after reset", v, 16'h0000);
        end
    endtask

    task automatic t_format();
        logic [15:0] v;
        cfg_left_align = 1'b0;
        put(4'd2, 12'hABC);
        get(4'd2, v); check("R3 right single", v, 16'h0ABC);
        cfg_left_align = 1'b1;
        put(4'd3, 12'hABC);
        get(4'd3, v); check("R3 left single", v, 16'hABC0);
        put(4'd8, 12'h123);
        get(4'd8, v); check("R2 diag index left", v, 16'h1230);
        cfg_left_align = 1'b0;
        get(4'd3, v); check("R3 format fixed at write", v, 16'hABC0);
        get(4'd2, v); check("R2 channel index", v, 16'h0ABC);
    endtask

    task automatic t_hold();
        logic [15:0] v;
        cfg_auto_clear = 1'b0;
        get(4'd2, v); check("R4 first read", v, 16'h0ABC);
        get(4'd2, v); check("R4 second read", v, 16'h0ABC);
        get(4'd12, v); check("R2 out of range read", v, 16'h0000);
    endtask

    task automatic t_autoclear();
        logic [15:0] v;
        cfg_auto_clear = 1'b1;
        get(4'd2, v); check("R5 read returns value", v, 16'h0ABC);
        get(4'd2, v); check("R5 cleared after read", v, 16'h0000);
        cfg_auto_clear = 1'b0;
        get(4'd3, v); check("R5 other register untouched", v, 16'hABC0);
    endtask

    task automatic t_add();
        logic [15:0] v;
        cfg_left_align = 1'b0; cfg_add_cnt = 2'd1;
        put(4'd1, 12'hFFF);
        get(4'd1, v); check("R7 no write mid group", v, 16'h0000);
        put(4'd1, 12'hFFF);
        get(4'd1, v); check("R6 two sample sum", v, 16'h1FFE);
        cfg_left_align = 1'b1; cfg_add_cnt = 2'd3;
        put(4'd4, 12'hFFF); put(4'd4, 12'hFFF); put(4'd4, 12'hFFF);
        get(4'd4, v); check("R7 no write after third of four", v, 16'h0000);
        put(4'd4, 12'hFFF);
        get(4'd4, v); check("R6 four sample sum left", v, 16'hFFF0);
        cfg_left_align = 1'b0; cfg_add_cnt = 2'd2;
        put(4'd5, 12'h100); put(4'd5, 12'h200); put(4'd5, 12'h300);
        get(4'd5, v); check("R6 three sample sum", v, 16'h0600);
        cfg_add_cnt = 2'd1;
        put(4'd6, 12'h001); put(4'd6, 12'h002);
        get(4'd6, v); check("R7 first group", v, 16'h0003);
        put(4'd6, 12'h010); put(4'd6, 12'h020);
        get(4'd6, v); check("R7 accumulator restarts", v, 16'h0030);
    endtask

    task automatic t_scope();
        logic [15:0] v;
        cfg_add_cnt = 2'd1; cfg_left_align = 1'b0;
        put(4'd10, 12'h800);
        get(4'd10, v); check("R8 reference mid group", v, 16'h0000);
        put(4'd10, 12'h800);
        get(4'd10, v); check("R8 reference summed", v, 16'h1000);
        put(4'd9, 12'h7FF);
        get(4'd9, v); check("R8 temperature single in add mode", v, 16'h07FF);
        put(4'd7, 12'h005);
        put(4'd9, 12'h111);
        put(4'd7, 12'h006);
        get(4'd9, v); check("R8 temperature inside group", v, 16'h0111);
        get(4'd7, v); check("R8 group survives side sample", v, 16'h000B);
        cfg_add_cnt = 2'd0;
    endtask

    task automatic t_collision();
        logic [15:0] v;
        cfg_auto_clear = 1'b1; cfg_left_align = 1'b0;
        put(4'd0, 12'h111);
        @(negedge clk);
        rd_en = 1'b1; rd_idx = 4'd0;
        smp_valid = 1'b1; smp_idx = 4'd0; smp_data = 12'h222;
        @(negedge clk);
        rd_en = 1'b0; smp_valid = 1'b0;
        check("R9 read returns prior value", rd_data, 16'h0111);
        get(4'd0, v); check("R9 write kept, not cleared", v, 16'h0222);
        get(4'd0, v); check("R5 cleared after later read", v, 16'h0000);
        cfg_auto_clear = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_format();
        t_hold();
        t_autoclear();
        t_add();
        t_scope();
        t_collision();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule